// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timer

This block sits between a transfer sequencer and the pins of a serial flash bus. It derives the serial clock from a fast reference clock, drives the chip-select lines, and places every edge of a transfer with programmable reference-cycle delays. The sequencer programs a small configuration word, pulses `start`, and waits for a one-cycle `done`. While the transfer runs, the block emits a strobe on each serial clock edge. The strobe marks the edge as either a sampling edge or a shifting edge, so that a separate shifter can move data in step with the clock.

A transfer passes through these phases. First comes an optional device-switch wait, with chip-select still high. Then chip-select asserts and a lead delay runs, followed by the clocking phase. After the last clock edge a trail delay runs and chip-select deasserts. Finally a minimum deselect time elapses before `done`. The hardware adds fixed extra cycles to the trail and deselect delays on top of the programmed counts. The configuration is captured in shadow registers whenever the block is idle, so a change on the configuration inputs during a transfer has no effect until the next one.

Top module: `sflash_cs_timer`

## Requirements
- R1: With divider field D, each serial clock level lasts exactly D+1 reference cycles. A transfer with length field L makes exactly 2*(L+1) clock edges.
- R2: Outside the clocking phase the serial clock rests at the polarity bit `cfg_cpol`. The first edge of a transfer moves away from that level, and the clock is back at that level when `done` pulses.
- R3: Each clock edge produces a single-cycle strobe in the same cycle as the edge: `sample_stb` or `shift_stb`, never both. With `cfg_cpha`=0 the edges that move away from `cfg_cpol` (leading edges) are sampling edges. With `cfg_cpha`=1 the returning (trailing) edges are sampling edges. Each transfer has L+1 of each kind.
- R4: While chip-select is asserted, `cs_n` holds one value for the whole transfer. When `cfg_decode`=1 that value is `cfg_cs` itself. When `cfg_decode`=0 it is all ones except that bit `cfg_cs[1:0]` is 0. At all other times `cs_n` is all ones.
- R5: From the first cycle with chip-select asserted to the first clock edge there are `cfg_lead` + 1 + (D+1) reference cycles.
- R6: From the last clock edge to the first cycle with chip-select deasserted there are `cfg_trail` + 2*(D+1) + 3 reference cycles.
- R7: From chip-select deassertion to `done` there are `cfg_gap` + 2*(D+1) + 1 reference cycles. `done` is high for one cycle.
- R8: If the chip-select value of an accepted transfer differs from that of the previous accepted transfer, chip-select asserts 1 + `cfg_switch` cycles after the cycle in which `start` was high. Otherwise it asserts after 1 cycle. The first transfer after reset counts as no switch.
- R9: With `enable` low, `start` is ignored: `cs_n` stays all ones and `idle` stays 1. Dropping `enable` during a transfer deasserts chip-select in the next cycle. It also returns the clock to `cfg_cpol` within two cycles, raises `idle`, and produces no `done`.
- R10: `idle` is 1 exactly when no transfer is in progress. It is 1 after reset, 0 from the cycle after `start` is accepted until `done`, and 1 in the `done` cycle.
- R11: Changing the divider or the delay inputs during a transfer alters neither the clock period nor the timing of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; low aborts and blocks transfers |
| start | input | 1 | Request a transfer (accepted when idle and enabled) |
| cfg_div | input | 4 | Clock divider field D, half period D+1 |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Selects trailing edges as sampling edges |
| cfg_decode | input | 1 | Drive `cfg_cs` straight to the pins |
| cfg_cs | input | 4 | Chip-select field (raw value or device index) |
| cfg_len | input | 6 | Clock cycles per transfer minus one |
| cfg_lead | input | 8 | Select-to-first-edge delay count |
| cfg_trail | input | 8 | Last-edge-to-deselect delay count |
| cfg_gap | input | 8 | Minimum deselect time count |
| cfg_switch | input | 8 | Extra wait when the selected device changes |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low chip-select lines |
| sample_stb | output | 1 | Strobe in the cycle of a sampling edge |
| shift_stb | output | 1 | Strobe in the cycle of a shifting edge |
| done | output | 1 | One-cycle end-of-transfer pulse |
| idle | output | 1 | No transfer in progress |

## Verification
The hardest condition to reach is a configuration change that lands in the middle of a transfer. It must leave the running transfer intact and take effect on the next one. The stimulus reaches this by changing the divider and the trail count in the same cycle that chip-select is first seen low. The bench then measures every half period and the trail time against the original values, and runs a clean transfer afterwards.

The device-switch delay depends on history, so the bench keeps its own record of the last accepted chip-select value. It orders the transfers so that this value repeats, changes under index mode, and changes under decode mode. The abort path is reached by dropping `enable` after the first clock edge has been observed.

// File: rtl/sfct_pkg.sv
package sfct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SWITCH = 3'd1,
    ST_LEAD   = 3'd2,
    ST_CLK    = 3'd3,
    ST_TAIL   = 3'd4,
    ST_GAP    = 3'd5
  } sfct_state_e;

endpackage

// File: rtl/sfct_cs_map.sv
module sfct_cs_map #(
  parameter int CS_W  = 4,
  parameter int SEL_W = 2
) (
  input  logic            decode,
  input  logic [CS_W-1:0] field,
  output logic [CS_W-1:0] pattern
);

  for (genvar i = 0; i < CS_W; i++) begin : g_line
    assign pattern[i] = decode ? field[i] : (field[SEL_W-1:0] != SEL_W'(i));
  end

endmodule

// File: rtl/sfct_clkgen.sv
module sfct_clkgen #(
  parameter int DIV_W = 4,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [LEN_W-1:0] len_m1,
  output logic             sclk,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             last_edge
);

  localparam int EC_W = LEN_W + 1;

  logic [DIV_W-1:0] hc_q, hc_d;
  logic [EC_W-1:0]  ec_q, ec_d;
  logic             sclk_q, sclk_d;
  logic             smp_q, smp_d;
  logic             shf_q, shf_d;
  logic             toggle;

  assign toggle    = run && (hc_q == '0);
  assign last_edge = toggle && (ec_q == {len_m1, 1'b1});

  always_comb begin
    hc_d   = hc_q;
    ec_d   = ec_q;
    sclk_d = sclk_q;
    smp_d  = 1'b0;
    shf_d  = 1'b0;
    if (!run) begin
      hc_d   = div;
      ec_d   = '0;
      sclk_d = cpol;
    end else if (toggle) begin
      hc_d   = div;
      ec_d   = ec_q + 1'b1;
      sclk_d = ~sclk_q;
      smp_d  = (ec_q[0] == cpha);
      shf_d  = (ec_q[0] != cpha);
    end else begin
      hc_d = hc_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q   <= '0;
      ec_q   <= '0;
      sclk_q <= 1'b0;
      smp_q  <= 1'b0;
      shf_q  <= 1'b0;
    end else begin
      hc_q   <= hc_d;
      ec_q   <= ec_d;
      sclk_q <= sclk_d;
      smp_q  <= smp_d;
      shf_q  <= shf_d;
    end
  end

  assign sclk       = sclk_q;
  assign sample_stb = smp_q;
  assign shift_stb  = shf_q;

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

  a_r3_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || shift_stb) |-> (sclk != $past(sclk)));

  a_r1_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ec_q <= {len_m1, 1'b1}));

endmodule

// File: rtl/sfct_seq.sv
module sfct_seq
  import sfct_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             need_switch,
  input  logic [DIV_W-1:0] div,
  input  logic [DLY_W-1:0] d_switch,
  input  logic [DLY_W-1:0] d_lead,
  input  logic [DLY_W-1:0] d_trail,
  input  logic [DLY_W-1:0] d_gap,
  input  logic             last_edge,
  output sfct_state_e      state,
  output logic             done
);

  sfct_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d;
  logic [CNT_W-1:0] period;

  // one serial clock period in reference cycles
  assign period = (CNT_W'(div) + 1'b1) << 1;

  always_comb begin
    st_d   = st_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (enable && start) begin
          if (need_switch && (d_switch != '0)) begin
            st_d  = ST_SWITCH;
            cnt_d = CNT_W'(d_switch) - 1'b1;
          end else begin
            st_d  = ST_LEAD;
            cnt_d = CNT_W'(d_lead);
          end
        end
      end
      ST_SWITCH: begin
        if (cnt_q == '0) begin
          st_d  = ST_LEAD;
          cnt_d = CNT_W'(d_lead);
        end
      end
      ST_LEAD: begin
        if (cnt_q == '0) st_d = ST_CLK;
      end
      ST_CLK: begin
        if (last_edge) begin
          st_d  = ST_TAIL;
          cnt_d = CNT_W'(d_trail) + period + CNT_W'(2);
        end
      end
      ST_TAIL: begin
        if (cnt_q == '0) begin
          st_d  = ST_GAP;
          cnt_d = CNT_W'(d_gap) + period;
        end
      end
      ST_GAP: begin
        if (cnt_q == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if ((st_q != ST_IDLE) && !enable) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      done  <= done_d;
    end
  end

  assign state = st_q;

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE));

  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != ST_IDLE) && !enable) |=> (state == ST_IDLE) && !done);

endmodule

// File: rtl/sflash_cs_timer.sv
module sflash_cs_timer
  import sfct_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CS_W  = 4,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_decode,
  input  logic [CS_W-1:0]  cfg_cs,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [DLY_W-1:0] cfg_lead,
  input  logic [DLY_W-1:0] cfg_trail,
  input  logic [DLY_W-1:0] cfg_gap,
  input  logic [DLY_W-1:0] cfg_switch,
  output logic             sclk,
  output logic [CS_W-1:0]  cs_n,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             done,
  output logic             idle
);

  localparam int SEL_W = (CS_W > 1) ? $clog2(CS_W) : 1;
  localparam int CNT_W = $clog2((1 << DLY_W) + (4 << DIV_W) + 4);

  sfct_state_e state;
  logic        in_idle, in_clk, active, accept;

  // shadow configuration, captured only while idle
  logic [DIV_W-1:0] div_q;
  logic             cpol_q, cpha_q, dec_q;
  logic [CS_W-1:0]  cs_q;
  logic [LEN_W-1:0] len_q;
  logic [DLY_W-1:0] lead_q, trail_q, gap_q, sw_q;

  logic [DIV_W-1:0] div_e;
  logic             cpol_e, cpha_e, dec_e;
  logic [CS_W-1:0]  cs_e;
  logic [LEN_W-1:0] len_e;
  logic [DLY_W-1:0] lead_e, trail_e, gap_e, sw_e;

  logic [CS_W-1:0]  pattern;
  logic [CS_W-1:0]  last_pat_q;
  logic             last_vld_q;
  logic             need_switch;
  logic             last_edge;

  assign in_idle = (state == ST_IDLE);
  assign in_clk  = (state == ST_CLK);
  assign active  = (state == ST_LEAD) || (state == ST_CLK) || (state == ST_TAIL);
  assign accept  = in_idle && enable && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      dec_q   <= 1'b0;
      cs_q    <= '0;
      len_q   <= '0;
      lead_q  <= '0;
      trail_q <= '0;
      gap_q   <= '0;
      sw_q    <= '0;
    end else if (in_idle) begin
      div_q   <= cfg_div;
      cpol_q  <= cfg_cpol;
      cpha_q  <= cfg_cpha;
      dec_q   <= cfg_decode;
      cs_q    <= cfg_cs;
      len_q   <= cfg_len;
      lead_q  <= cfg_lead;
      trail_q <= cfg_trail;
      gap_q   <= cfg_gap;
      sw_q    <= cfg_switch;
    end
  end

  assign div_e   = in_idle ? cfg_div    : div_q;
  assign cpol_e  = in_idle ? cfg_cpol   : cpol_q;
  assign cpha_e  = in_idle ? cfg_cpha   : cpha_q;
  assign dec_e   = in_idle ? cfg_decode : dec_q;
  assign cs_e    = in_idle ? cfg_cs     : cs_q;
  assign len_e   = in_idle ? cfg_len    : len_q;
  assign lead_e  = in_idle ? cfg_lead   : lead_q;
  assign trail_e = in_idle ? cfg_trail  : trail_q;
  assign gap_e   = in_idle ? cfg_gap    : gap_q;
  assign sw_e    = in_idle ? cfg_switch : sw_q;

  sfct_cs_map #(.CS_W(CS_W), .SEL_W(SEL_W)) u_map (
    .decode  (dec_e),
    .field   (cs_e),
    .pattern (pattern)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pat_q <= '1;
      last_vld_q <= 1'b0;
    end else if (accept) begin
      last_pat_q <= pattern;
      last_vld_q <= 1'b1;
    end
  end

  assign need_switch = last_vld_q && (pattern != last_pat_q);

  sfct_clkgen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (in_clk),
    .div        (div_e),
    .cpol       (cpol_e),
    .cpha       (cpha_e),
    .len_m1     (len_e),
    .sclk       (sclk),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .last_edge  (last_edge)
  );

  sfct_seq #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .start       (start),
    .need_switch (need_switch),
    .div         (div_e),
    .d_switch    (sw_e),
    .d_lead      (lead_e),
    .d_trail     (trail_e),
    .d_gap       (gap_e),
    .last_edge   (last_edge),
    .state       (state),
    .done        (done)
  );

  assign cs_n = active ? pattern : '1;
  assign idle = in_idle;

  a_r4_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(cs_n));

  a_r4_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dec_e) |-> ($countones(~cs_n) == 1));

  a_r11_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && !$past(in_idle)) |-> $stable(div_e));

  a_r2_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_clk) |-> (sclk == $past(cpol_e)));

endmodule

// File: tb/sflash_cs_timer_tb.sv
module sflash_cs_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable, start;
  logic [3:0] cfg_div;
  logic       cfg_cpol, cfg_cpha, cfg_decode;
  logic [3:0] cfg_cs;
  logic [5:0] cfg_len;
  logic [7:0] cfg_lead, cfg_trail, cfg_gap, cfg_switch;
  logic       sclk;
  logic [3:0] cs_n;
  logic       sample_stb, shift_stb, done, idle;

  int n_checks = 0;
  int n_err    = 0;
  logic [3:0] last_pat = 4'hF;
  bit         last_vld = 0;

  always #5 clk = ~clk;

  sflash_cs_timer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_decode(cfg_decode), .cfg_cs(cfg_cs), .cfg_len(cfg_len),
    .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .cfg_gap(cfg_gap),
    .cfg_switch(cfg_switch), .sclk(sclk), .cs_n(cs_n),
    .sample_stb(sample_stb), .shift_stb(shift_stb), .done(done), .idle(idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_pat(input int dec, input int sel);
    logic [3:0] p;
    if (dec != 0) p = sel[3:0];
    else p = ~(4'b0001 << sel[1:0]);
    return p;
  endfunction

  task automatic run_xfer(input int dv, input int cp, input int ph, input int ln,
                          input int dec, input int sel, input int da, input int dt,
                          input int dg, input int ds, input bit mid);
    int h, n, cyc, t_fall, t_rise, t_first, t_last, t_done;
    int nchg, bad_int, bad_cs, bad_idle, nsmp, nsh, bad_pol;
    logic prev_sclk, sclk_done;
    logic [3:0] pat;
    bit sw;
    h = dv + 1; n = ln + 1;
    pat = exp_pat(dec, sel);
    sw = last_vld && (pat != last_pat);
    last_pat = pat; last_vld = 1;
    t_fall = -1; t_rise = -1; t_first = -1; t_last = -1; t_done = -1;
    nchg = 0; bad_int = 0; bad_cs = 0; bad_idle = 0; nsmp = 0; nsh = 0; bad_pol = 0;
    sclk_done = 1'b0;
    @(negedge clk);
    cfg_div = dv[3:0]; cfg_cpol = cp[0]; cfg_cpha = ph[0]; cfg_len = ln[5:0];
    cfg_decode = dec[0]; cfg_cs = sel[3:0]; cfg_lead = da[7:0]; cfg_trail = dt[7:0];
    cfg_gap = dg[7:0]; cfg_switch = ds[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    prev_sclk = sclk;
    for (int guard = 0; guard < 3000 && t_done < 0; guard++) begin
      bit chg;
      chg = (cyc > 1) && (sclk != prev_sclk);
      if (cs_n != 4'hF) begin
        if (t_fall < 0) begin
          t_fall = cyc;
          if (mid) begin
            cfg_div = dv[3:0] ^ 4'd1;
            cfg_trail = dt[7:0] + 8'd9;
          end
        end
        if (cs_n != pat) bad_cs++;
      end else if (t_fall >= 0 && t_rise < 0) t_rise = cyc;
      if (chg) begin
        if (t_last >= 0 && (cyc - t_last) != h) bad_int++;
        if (t_first < 0) t_first = cyc;
        t_last = cyc;
        nchg++;
      end
      if (sample_stb) begin
        nsmp++;
        if (((sclk != cp[0]) != (ph == 0)) || !chg) bad_pol++;
      end
      if (shift_stb) begin
        nsh++;
        if (!chg) bad_pol++;
      end
      if (done) begin
        t_done = cyc;
        sclk_done = sclk;
        if (!idle) bad_idle++;
      end else if (idle) bad_idle++;
      prev_sclk = sclk;
      cyc++;
      @(negedge clk);
    end
    chk(t_fall == 1 + (sw ? ds : 0), "R8 start to select", t_fall, 1 + (sw ? ds : 0));
    chk(bad_cs == 0, "R4 select value", bad_cs, 0);
    chk(t_first - t_fall == da + 1 + h, "R5 lead", t_first - t_fall, da + 1 + h);
    chk(nchg == 2 * n, "R1 edge count", nchg, 2 * n);
    chk(bad_int == 0, mid ? "R11 half period after change" : "R1 half period", bad_int, 0);
    chk(t_rise - t_last == dt + 2 * h + 3, mid ? "R11 trail after change" : "R6 trail",
        t_rise - t_last, dt + 2 * h + 3);
    chk(t_done - t_rise == dg + 2 * h + 1, "R7 deselect", t_done - t_rise, dg + 2 * h + 1);
    chk(nsmp == n && nsh == n, "R3 strobe counts", nsmp * 100 + nsh, n * 100 + n);
    chk(bad_pol == 0, "R3 strobe edge kind", bad_pol, 0);
    chk(bad_idle == 0, "R10 idle during transfer", bad_idle, 0);
    chk(sclk_done == cp[0], "R2 rest level", int'(sclk_done), cp);
  endtask

  initial begin
    #(10 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    int bad;
    rst_n = 1'b0; enable = 1'b0; start = 1'b0;
    cfg_div = '0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_decode = 1'b0;
    cfg_cs = '0; cfg_len = '0; cfg_lead = '0; cfg_trail = '0; cfg_gap = '0;
    cfg_switch = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(cs_n == 4'hF, "R4 reset deselected", int'(cs_n), 15);
    chk(idle == 1'b1 && done == 1'b0, "R10 reset idle", int'({idle, done}), 2);
    chk(sclk == 1'b0, "R2 reset level", int'(sclk), 0);

    // start ignored while disabled
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (cs_n != 4'hF || !idle || done) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 start ignored when disabled", bad, 0);
    enable = 1'b1;

    // sweep of divider, mode and length
    for (int dv = 0; dv < 4; dv++)
      for (int md = 0; md < 4; md++)
        for (int ln = 0; ln < 3; ln++)
          run_xfer(dv, md >> 1, md & 1, ln, 0, 0, dv, 1, 2, 5, 1'b0);

    // device index sweep with switch delay, then repeat without switch
    for (int s = 1; s < 4; s++) run_xfer(1, 0, 0, 0, 0, s, 0, 0, 0, 4 + s, 1'b0);
    run_xfer(1, 1, 1, 1, 0, 3, 0, 0, 0, 7, 1'b0);
    // decode mode: raw value reaches pins, value change triggers switch
    run_xfer(0, 0, 1, 1, 1, 5, 1, 1, 1, 3, 1'b0);
    run_xfer(0, 0, 1, 1, 1, 5, 1, 1, 1, 3, 1'b0);
    run_xfer(2, 1, 0, 0, 1, 12, 2, 0, 3, 0, 1'b0);
    // large delays and largest divider
    run_xfer(15, 0, 1, 1, 1, 12, 20, 30, 40, 9, 1'b0);
    // mid-transfer configuration change, then a clean transfer with new value
    run_xfer(2, 0, 0, 2, 0, 1, 3, 4, 2, 6, 1'b1);
    run_xfer(3, 0, 0, 2, 0, 1, 3, 4, 2, 6, 1'b0);

    // abort by dropping enable after the first edge
    @(negedge clk);
    cfg_div = 4'd3; cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_len = 6'd4;
    cfg_decode = 1'b0; cfg_cs = 4'd2; cfg_lead = 8'd1; cfg_trail = 8'd1;
    cfg_gap = 8'd1; cfg_switch = 8'd0;
    last_pat = exp_pat(0, 2); last_vld = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 100 && sclk == 1'b1; g++) @(negedge clk);
    chk(sclk == 1'b0 && cs_n == exp_pat(0, 2), "R9 abort reached clocking", int'(cs_n), int'(exp_pat(0, 2)));
    enable = 1'b0;
    @(negedge clk);
    chk(cs_n == 4'hF && idle, "R9 abort deselects", int'(cs_n), 15);
    @(negedge clk);
    chk(sclk == 1'b1, "R9 abort clock level", int'(sclk), 1);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (done || cs_n != 4'hF || sclk != 1'b1) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 no done after abort", bad, 0);
    enable = 1'b1;
    run_xfer(0, 1, 0, 0, 0, 2, 0, 0, 0, 2, 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule